// File: doc/BRIEF.md
# MDIO Managed-Device Responder

This block is the target end of a two-wire management bus. It oversamples the management clock and data line with its own system clock, locks onto a run of at least 32 ones, and then decodes one frame. The frame names a port and either a register (short format) or a device (extended format). When the port field equals the strapped port address, the block turns the frame into a single-cycle read or write strobe toward a small local register space.

The extended format reaches registers through a held 16-bit address. An address frame loads it. Later write and read frames use it, and a read-with-increment frame advances it after use. For reads, the block drives the line only during the turnaround and data field. It uses a data/enable pair so that a pad or a pull-up resolves the shared wire.

Top module: `mdio_responder`

## Requirements
- R1: Decoding starts only when a 0 bit follows at least 32 consecutive 1 bits, all sampled on MDC rising edges. A frame whose preamble has fewer ones produces no strobe and no drive.
- R2: A 0 start bit followed by 1 selects the short format. Opcode 01 writes and 10 reads the register given by the 5-bit register field, zero-extended to 16 bits. The held address is neither used nor changed.
- R3: A 0 start bit followed by 0 selects the extended format. Opcode 00 loads the 16-bit data field into the held address. Opcode 01 writes to the held address and opcode 11 reads from it, and neither changes it.
- R4: Extended opcode 10 reads from the held address and then adds one to it, wrapping from 0xFFFF to 0x0000.
- R5: A frame whose 5-bit port field differs from `port_addr_i` produces no strobe and no drive, and does not change the held address.
- R6: A short-format frame with opcode 00 or 11 is dropped. It produces no strobe and no drive, and the block returns to preamble hunting.
- R7: During a matched read, the line is released for the first turnaround bit and driven 0 for the second. The 16 data bits follow MSB first, and the line is released after the last data bit. Out of reset, the line is released.
- R8: For a matched write, `reg_wr_o` pulses for exactly one clock after the 16th data bit is sampled. `reg_addr_o` and `reg_wdata_o` are valid in that cycle, with data taken MSB first.
- R9: For a matched read, `reg_rd_o` pulses for exactly one clock right after the last header bit is sampled. `reg_rdata_i` is taken in that cycle for `reg_addr_o`. Read and write strobes never coincide.
- R10: `mdio_o` and `mdio_oe` change only in the clock after a detected MDC rising edge. Each field bit is sampled MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_i | input | 1 | Management clock from the bus master |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Value to drive onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| port_addr_i | input | 5 | Strapped port address of this device |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | 16 | Register address for the strobes |
| reg_wdata_o | output | 16 | Write data, valid with `reg_wr_o` |
| reg_rdata_i | input | 16 | Read data, taken with `reg_rd_o` |

## Verification
A read-with-increment frame issues its read strobe on the same clock edge that advances the held address. That edge must publish the old address and store the new one. Back-to-back increment reads starting at 0xFFFE provoke this. Each read strobe address and each returned data word is compared with the expected sequence FFFE, FFFF, 0000. A plain extended read then confirms that 0001 was left behind.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

  typedef enum logic [1:0] {ST_HUNT, ST_HDR, ST_TA, ST_DATA} frame_st_e;
  typedef enum logic [1:0] {ACT_ADDR, ACT_WRITE, ACT_READ, ACT_READ_INC} act_e;

  // Short format accepts only write (01) and read (10); extended accepts all.
  function automatic logic op_legal(input logic ext, input logic [1:0] op);
    return ext ? 1'b1 : ((op == 2'b01) || (op == 2'b10));
  endfunction

  function automatic act_e op_decode(input logic ext, input logic [1:0] op);
    if (!ext) return (op == 2'b01) ? ACT_WRITE : ACT_READ;
    case (op)
      2'b00:   return ACT_ADDR;
      2'b01:   return ACT_WRITE;
      2'b11:   return ACT_READ;
      default: return ACT_READ_INC;
    endcase
  endfunction

  function automatic logic act_is_read(input act_e a);
    return (a == ACT_READ) || (a == ACT_READ_INC);
  endfunction

  function automatic logic [15:0] addr_advance(input logic [15:0] a, input act_e act);
    return (act == ACT_READ_INC) ? 16'(a + 16'd1) : a;
  endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic mdc_rise,
  output logic mdio_bit
);
  logic [STAGES-1:0] mdc_sr;
  logic [STAGES-1:0] dat_sr;
  logic              mdc_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_sr   <= '0;
      dat_sr   <= '1;
      mdc_prev <= 1'b0;
    end else begin
      mdc_sr   <= {mdc_sr[STAGES-2:0], mdc_i};
      dat_sr   <= {dat_sr[STAGES-2:0], mdio_i};
      mdc_prev <= mdc_sr[STAGES-1];
    end
  end

  assign mdc_rise = mdc_sr[STAGES-1] & ~mdc_prev;
  assign mdio_bit = dat_sr[STAGES-1];
endmodule

// File: rtl/mdio_preamble_det.sv
module mdio_preamble_det #(
  parameter int PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt,
  input  logic bit_rise,
  input  logic bit_val,
  output logic start_seen
);
  localparam int CW = $clog2(PRE_LEN + 1);
  logic [CW-1:0] ones;
  logic          full;

  assign full       = (ones == CW'(PRE_LEN));
  assign start_seen = hunt & bit_rise & ~bit_val & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones <= '0;
    else if (!hunt) ones <= '0;
    else if (bit_rise) begin
      if (!bit_val) ones <= '0;
      else if (!full) ones <= ones + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_read_shifter.sv
module mdio_read_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              ta_zero,
  input  logic              shift_out,
  input  logic              release_line,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      if (load) sh <= load_val;
      if (ta_zero) begin
        mdio_oe <= 1'b1;
        mdio_o  <= 1'b0;
      end else if (shift_out) begin
        mdio_oe <= 1'b1;
        mdio_o  <= sh[DATA_W-1];
        sh      <= sh << 1;
      end else if (release_line) begin
        mdio_oe <= 1'b0;
        mdio_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_responder.sv
module mdio_responder
  import mdio_resp_pkg::*;
#(
  parameter int PRE_LEN     = 32,
  parameter int PORT_W      = 5,
  parameter int DEV_W       = 5,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic [PORT_W-1:0] port_addr_i,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int HDR_BITS = 1 + 2 + PORT_W + DEV_W;
  localparam int HCNT_W   = $clog2(HDR_BITS);
  localparam int DCNT_W   = $clog2(DATA_W);

  logic mdc_rise, mdio_bit, start_seen;
  frame_st_e state;
  logic [HDR_BITS-2:0] hdr_sr;
  logic [HDR_BITS-1:0] hdr_next;
  logic [HCNT_W-1:0]   hdr_cnt;
  logic [DATA_W-2:0]   data_sr;
  logic [DATA_W-1:0]   data_next;
  logic [DCNT_W-1:0]   dat_cnt;
  logic                ta_cnt;
  act_e                act_q;
  logic [DATA_W-1:0]   addr_q;

  mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc_i), .mdio_i(mdio_i),
    .mdc_rise(mdc_rise), .mdio_bit(mdio_bit));

  mdio_preamble_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk(clk), .rst_n(rst_n), .hunt(state == ST_HUNT), .bit_rise(mdc_rise),
    .bit_val(mdio_bit), .start_seen(start_seen));

  // Header decode on the bit that completes it
  logic              hdr_last, hdr_done, hdr_ext, hdr_match, hdr_ok, inc_fire;
  logic [1:0]        hdr_op;
  act_e              hdr_act;
  logic [DATA_W-1:0] short_addr;

  assign hdr_next   = {hdr_sr, mdio_bit};
  assign hdr_last   = (hdr_cnt == HCNT_W'(HDR_BITS - 1));
  assign hdr_done   = mdc_rise && (state == ST_HDR) && hdr_last;
  assign hdr_ext    = ~hdr_next[HDR_BITS-1];
  assign hdr_op     = hdr_next[HDR_BITS-2 -: 2];
  assign hdr_match  = (hdr_next[DEV_W +: PORT_W] == port_addr_i);
  assign hdr_ok     = op_legal(hdr_ext, hdr_op) && hdr_match;
  assign hdr_act    = op_decode(hdr_ext, hdr_op);
  assign short_addr = {{(DATA_W-DEV_W){1'b0}}, hdr_next[DEV_W-1:0]};
  assign inc_fire   = hdr_done && hdr_ok && hdr_ext && (hdr_act == ACT_READ_INC);

  // Data field events
  logic dat_last, data_done, addr_load, rd_act;
  assign data_next = {data_sr, mdio_bit};
  assign dat_last  = (dat_cnt == DCNT_W'(DATA_W - 1));
  assign data_done = mdc_rise && (state == ST_DATA) && dat_last;
  assign addr_load = data_done && (act_q == ACT_ADDR);
  assign rd_act    = act_is_read(act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_HUNT;
      hdr_sr      <= '0;
      hdr_cnt     <= '0;
      data_sr     <= '0;
      dat_cnt     <= '0;
      ta_cnt      <= 1'b0;
      act_q       <= ACT_ADDR;
      addr_q      <= '0;
      reg_rd_o    <= 1'b0;
      reg_wr_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
    end else begin
      reg_rd_o <= 1'b0;
      reg_wr_o <= 1'b0;
      if (mdc_rise) begin
        unique case (state)
          ST_HUNT: if (start_seen) begin
            state   <= ST_HDR;
            hdr_cnt <= '0;
          end
          ST_HDR: begin
            hdr_sr  <= hdr_next[HDR_BITS-2:0];
            hdr_cnt <= hdr_cnt + 1'b1;
            if (hdr_last) begin
              if (!hdr_ok) state <= ST_HUNT;
              else begin
                state  <= ST_TA;
                ta_cnt <= 1'b0;
                act_q  <= hdr_act;
                if (hdr_act != ACT_ADDR) reg_addr_o <= hdr_ext ? addr_q : short_addr;
                if (act_is_read(hdr_act)) reg_rd_o <= 1'b1;
                if (hdr_ext) addr_q <= addr_advance(addr_q, hdr_act);
              end
            end
          end
          ST_TA: begin
            if (ta_cnt) begin
              state   <= ST_DATA;
              dat_cnt <= '0;
            end else ta_cnt <= 1'b1;
          end
          ST_DATA: begin
            data_sr <= data_next[DATA_W-2:0];
            dat_cnt <= dat_cnt + 1'b1;
            if (dat_last) begin
              state <= ST_HUNT;
              if (act_q == ACT_WRITE) begin
                reg_wr_o    <= 1'b1;
                reg_wdata_o <= data_next;
              end
            end
          end
        endcase
      end
      if (addr_load) addr_q <= data_next;
    end
  end

  // Line drive controls for reads
  logic ta_zero, shift_out, release_line;
  assign ta_zero      = mdc_rise && rd_act && (state == ST_TA) && !ta_cnt;
  assign shift_out    = mdc_rise && rd_act &&
                        (((state == ST_TA) && ta_cnt) || ((state == ST_DATA) && !dat_last));
  assign release_line = data_done && rd_act;

  mdio_read_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(reg_rd_o), .load_val(reg_rdata_i),
    .ta_zero(ta_zero), .shift_out(shift_out), .release_line(release_line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe));
endmodule

// File: rtl/mdio_responder_chk.sv
module mdio_responder_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mdc_rise,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              reg_rd_o,
  input logic              reg_wr_o,
  input logic              hdr_done,
  input logic              hdr_match,
  input logic              addr_load,
  input logic              inc_fire,
  input logic [DATA_W-1:0] data_next,
  input logic [DATA_W-1:0] addr_q
);
  // R9
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_o && reg_wr_o));
  // R9
  rd_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |-> $past(hdr_done));
  // R8
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);
  // R10
  oe_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> $past(mdc_rise));
  // R10
  out_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $past(mdc_rise));
  // R7
  ta_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  // R5
  mismatch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && !hdr_match) |=> (!reg_rd_o && $stable(addr_q)));
  // R3
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> (addr_q == $past(data_next)));
  // R4
  inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_fire |=> (addr_q == DATA_W'($past(addr_q) + 1'b1)));
endmodule

bind mdio_responder mdio_responder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o),
  .hdr_done(hdr_done), .hdr_match(hdr_match), .addr_load(addr_load),
  .inc_fire(inc_fire), .data_next(data_next), .addr_q(addr_q));

// File: tb/mdio_responder_bench.sv
`timescale 1ns/1ps
module mdio_responder_bench;
  localparam logic [4:0] MY_PORT = 5'h13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0;
  logic m_oe = 1'b0;
  logic m_val = 1'b0;
  logic bus;
  logic mdio_o, mdio_oe, reg_rd_o, reg_wr_o;
  logic [15:0] reg_addr_o, reg_wdata_o, reg_rdata_i;

  always #4 clk = ~clk;

  function automatic logic [15:0] rmodel(input logic [15:0] a);
    return 16'(a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  assign bus = mdio_oe ? mdio_o : (m_oe ? m_val : 1'b1);
  assign reg_rdata_i = rmodel(reg_addr_o);

  mdio_responder u_mdio_responder (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc), .mdio_i(bus),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .port_addr_i(MY_PORT),
    .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i));

  // Passive monitor of strobes and drive
  int wr_n = 0, rd_n = 0, oe_n = 0;
  logic [15:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  always @(posedge clk) begin
    if (reg_wr_o) begin wr_n <= wr_n + 1; wr_addr <= reg_addr_o; wr_data <= reg_wdata_o; end
    if (reg_rd_o) begin rd_n <= rd_n + 1; rd_addr <= reg_addr_o; end
    if (mdio_oe) oe_n <= oe_n + 1;
  end

  int checks = 0, failures = 0;
  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic drive, input logic val, output logic seen);
    @(negedge clk); m_oe = drive; m_val = val; mdc = 1'b0;
    repeat (3) @(negedge clk);
    seen = bus;
    @(negedge clk); mdc = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input int npre, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] prt, input logic [4:0] dev, input logic [15:0] wd,
                       input logic rd, output logic [17:0] got);
    logic s;
    logic [13:0] hdr;
    hdr = {st, op, prt, dev};
    got = '1;
    for (int i = 0; i < npre; i++) bit_cycle(1'b1, 1'b1, s);
    for (int i = 13; i >= 0; i--) bit_cycle(1'b1, hdr[i], s);
    if (rd) begin
      for (int i = 17; i >= 0; i--) begin bit_cycle(1'b0, 1'b0, s); got[i] = s; end
    end else begin
      bit_cycle(1'b1, 1'b1, s);
      bit_cycle(1'b1, 1'b0, s);
      for (int i = 15; i >= 0; i--) bit_cycle(1'b1, wd[i], s);
    end
    bit_cycle(1'b0, 1'b0, s);
    bit_cycle(1'b0, 1'b0, s);
  endtask

  task automatic zero_bit();
    logic s;
    bit_cycle(1'b1, 1'b0, s);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [17:0] got;
    int w0, r0, o0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R7 reset: line released, no strobes
    chk(!mdio_oe && wr_n == 0 && rd_n == 0, "R7 reset idle", {mdio_oe, 31'(wr_n)}, 0);

    // R2/R8 short writes over every register
    for (int d = 0; d < 32; d++) begin
      logic [15:0] wd;
      wd = 16'(d * 16'h0101) ^ 16'hC3A5;
      w0 = wr_n;
      frame(32, 2'b01, 2'b01, MY_PORT, 5'(d), wd, 1'b0, got);
      chk(wr_n - w0 == 1, "R8 one write strobe", 32'(wr_n - w0), 1);
      chk(wr_addr == 16'(d), "R2 short write addr", wr_addr, 32'(d));
      chk(wr_data == wd, "R8 write data", wr_data, wd);
    end

    // R2/R7/R9 short reads over every register
    for (int d = 0; d < 32; d++) begin
      r0 = rd_n;
      frame(32, 2'b01, 2'b10, MY_PORT, 5'(d), 16'h0, 1'b1, got);
      chk(rd_n - r0 == 1, "R9 one read strobe", 32'(rd_n - r0), 1);
      chk(rd_addr == 16'(d), "R2 short read addr", rd_addr, 32'(d));
      chk(got == {2'b10, rmodel(16'(d))}, "R7 read ta+data", got, {2'b10, rmodel(16'(d))});
      chk(!mdio_oe, "R7 released after data", mdio_oe, 0);
    end

    // R3 extended address, write, read
    frame(32, 2'b00, 2'b00, MY_PORT, 5'd3, 16'h1234, 1'b0, got);
    w0 = wr_n;
    frame(32, 2'b00, 2'b01, MY_PORT, 5'd3, 16'hBEEF, 1'b0, got);
    chk(wr_n - w0 == 1 && wr_addr == 16'h1234, "R3 ext write addr", wr_addr, 16'h1234);
    chk(wr_data == 16'hBEEF, "R3 ext write data", wr_data, 16'hBEEF);
    for (int k = 0; k < 2; k++) begin
      frame(32, 2'b00, 2'b11, MY_PORT, 5'd3, 16'h0, 1'b1, got);
      chk(rd_addr == 16'h1234, "R3 ext read holds addr", rd_addr, 16'h1234);
      chk(got == {2'b10, rmodel(16'h1234)}, "R3 ext read data", got, {2'b10, rmodel(16'h1234)});
    end

    // R5 mismatched ports: reads, write, and address frame all ignored
    for (int p = 0; p < 32; p++) begin
      if (5'(p) != MY_PORT) begin
        r0 = rd_n; o0 = oe_n;
        frame(32, 2'b01, 2'b10, 5'(p), 5'd1, 16'h0, 1'b1, got);
        chk(rd_n == r0 && oe_n == o0 && got == '1, "R5 mismatch read quiet", got, 18'h3FFFF);
      end
    end
    w0 = wr_n;
    frame(32, 2'b01, 2'b01, MY_PORT ^ 5'h01, 5'd2, 16'h5555, 1'b0, got);
    chk(wr_n == w0, "R5 mismatch write ignored", 32'(wr_n - w0), 0);
    frame(32, 2'b00, 2'b00, MY_PORT ^ 5'h10, 5'd3, 16'h7777, 1'b0, got);
    frame(32, 2'b00, 2'b11, MY_PORT, 5'd3, 16'h0, 1'b1, got);
    chk(rd_addr == 16'h1234, "R5 held addr untouched", rd_addr, 16'h1234);

    // R1 short preamble ignored, full preamble accepted
    zero_bit();
    w0 = wr_n;
    frame(31, 2'b01, 2'b01, MY_PORT, 5'd9, 16'hA5A5, 1'b0, got);
    chk(wr_n == w0, "R1 31-one preamble ignored", 32'(wr_n - w0), 0);
    zero_bit();
    frame(32, 2'b01, 2'b01, MY_PORT, 5'd9, 16'hA5A5, 1'b0, got);
    chk(wr_n - w0 == 1 && wr_data == 16'hA5A5, "R1 32-one preamble accepted", wr_data, 16'hA5A5);
    zero_bit();
    frame(40, 2'b01, 2'b10, MY_PORT, 5'd9, 16'h0, 1'b1, got);
    chk(got == {2'b10, rmodel(16'd9)}, "R1 long preamble read", got, {2'b10, rmodel(16'd9)});

    // R6 illegal short opcodes
    w0 = wr_n; r0 = rd_n; o0 = oe_n;
    frame(32, 2'b01, 2'b00, MY_PORT, 5'd4, 16'hFFFF, 1'b0, got);
    frame(32, 2'b01, 2'b11, MY_PORT, 5'd4, 16'h0, 1'b1, got);
    chk(wr_n == w0 && rd_n == r0 && oe_n == o0, "R6 illegal op ignored", 32'(wr_n - w0 + rd_n - r0), 0);
    chk(got == '1, "R6 illegal op no drive", got, 18'h3FFFF);
    frame(32, 2'b01, 2'b10, MY_PORT, 5'd4, 16'h0, 1'b1, got);
    chk(got == {2'b10, rmodel(16'd4)}, "R6 recovers after illegal", got, {2'b10, rmodel(16'd4)});

    // R4 read-increment across the wrap
    frame(32, 2'b00, 2'b00, MY_PORT, 5'd1, 16'hFFFE, 1'b0, got);
    for (int k = 0; k < 3; k++) begin
      logic [15:0] ea;
      ea = 16'(16'hFFFE + k);
      r0 = rd_n;
      frame(32, 2'b00, 2'b10, MY_PORT, 5'd1, 16'h0, 1'b1, got);
      chk(rd_n - r0 == 1 && rd_addr == ea, "R4 inc read addr", rd_addr, ea);
      chk(got == {2'b10, rmodel(ea)}, "R4 inc read data", got, {2'b10, rmodel(ea)});
    end
    frame(32, 2'b00, 2'b11, MY_PORT, 5'd1, 16'h0, 1'b1, got);
    chk(rd_addr == 16'h0001, "R4 addr after wrap", rd_addr, 16'h0001);

    // R2 short read ignores the held address
    frame(32, 2'b01, 2'b10, MY_PORT, 5'd7, 16'h0, 1'b1, got);
    chk(rd_addr == 16'h0007, "R2 short bypasses held addr", rd_addr, 16'h0007);
    frame(32, 2'b00, 2'b11, MY_PORT, 5'd1, 16'h0, 1'b1, got);
    chk(rd_addr == 16'h0001, "R2 held addr unchanged by short", rd_addr, 16'h0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule